// File: doc/BRIEF.md
# Word-Serial Wide-Operand Multiplier

This block multiplies a wide unsigned multiplicand, captured as a vector of 16-bit words, by an unsigned multiplier that arrives one 16-bit word per step, least significant word first. In every step the incoming multiplier word is multiplied by each multiplicand word in parallel, using only 16x16 multipliers. Each 32-bit partial product is split into a low and a high half, and the high half is lined up one word column above its low half. The halves are folded into a running accumulator with full carry propagation. The lowest word of that sum is the next finished result word, and the accumulator then moves down by one word.

A run begins with a one-cycle `start` pulse, which also captures `a_in` and the `full_mode` select. Multiplier words enter on a valid/ready stream. Result words leave on a second valid/ready stream, lowest word first. An input word is accepted when `b_valid` and `b_ready` are both high at a clock edge, and an output word is taken when `r_valid` and `r_ready` are both high. A step advances only when the output register is empty or is being drained in that cycle. So a consumer that holds `r_ready` low stalls the whole pipeline, and `b_ready` stays low while it does. In full mode a run yields 2N words, and the second N steps use an internal zero multiplier word to flush the upper half. In truncated mode a run yields N words, which is the product modulo 2^(16N). `done` rises once the final word has been taken.

Top module: `serial_bigmul`

## Requirements
- R1: After reset, `r_valid`, `b_ready` and `done` are low.
- R2: In full mode (`full_mode`=1), a run emits 2N words. Word k equals bits [16k+15:16k] of the product of the N-word multiplicand and the N-word multiplier, where the multiplier word taken in the j-th input handshake is bits [16j+15:16j].
- R3: In truncated mode (`full_mode`=0), a run emits exactly N words, equal to the lower N words of the same product.
- R4: In every run, exactly N multiplier words are taken through the input handshake.
- R5: Once N multiplier words have been taken, `b_ready` stays low for the rest of the run, and any words or valids presented then have no effect on the result.
- R6: While `r_valid` is high and `r_ready` is low, `r_valid` stays high and `r_word` holds its value on the next cycle.
- R7: `done` is low from the cycle after an accepted `start` until the final result word is taken. It is high from the cycle after that handshake until the next accepted `start`.
- R8: A `start` pulse that arrives while a run is in progress or a result word is pending is ignored.
- R9: No carry is lost between word columns, including for all-ones operands, where every column carries.
- R10: The multiplicand is captured at the accepted `start`, and later changes on `a_in` do not affect the run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run; captures `a_in` and `full_mode` when idle |
| full_mode | input | 1 | 1: emit 2N words; 0: emit N words |
| a_in | input | 16*N | Multiplicand, word i in bits [16i+15:16i] |
| b_valid | input | 1 | Multiplier word is present |
| b_ready | output | 1 | Block takes a multiplier word this cycle |
| b_word | input | 16 | Multiplier word, least significant first |
| r_valid | output | 1 | Result word is present |
| r_ready | input | 1 | Consumer takes the result word |
| r_word | output | 16 | Result word, least significant first |
| done | output | 1 | All words of the last run have been taken |

## Verification
The bench sweeps a four-word configuration with all-zero, all-ones, single-one and random operands in both modes. Each result is compared with a big-integer product computed in the bench. All-ones operands target carry chains: a design that drops the high half, places it in the wrong column, or cuts a carry at a word boundary gives wrong upper words. Random gaps on `b_valid` and random stalls on `r_ready` target the handshakes: a design that loses a stalled word, takes a multiplier word while the output is blocked, or takes input during the flush would emit a wrong or shifted product. Stray `start` pulses and changes on `a_in` during a run would restart or corrupt a design that does not ignore them. `done` is watched throughout each run, so an early or missing completion flag is reported.

// File: rtl/smul_pkg.sv
package smul_pkg;
  localparam int unsigned SMUL_WW = 16;
  typedef logic [SMUL_WW-1:0] smul_word_t;
endpackage

// File: rtl/smul_pp_row.sv
module smul_pp_row
  import smul_pkg::*;
#(
  parameter int unsigned NW = 64,
  localparam int unsigned AW = NW * SMUL_WW
) (
  input  logic [AW-1:0] a_vec,
  input  smul_word_t    m_word,
  output logic [AW-1:0] lo_vec,
  output logic [AW-1:0] hi_vec
);
  for (genvar i = 0; i < NW; i++) begin : g_col
    logic [2*SMUL_WW-1:0] prod;
    assign prod = {{SMUL_WW{1'b0}}, a_vec[i*SMUL_WW +: SMUL_WW]} *
                  {{SMUL_WW{1'b0}}, m_word};
    assign lo_vec[i*SMUL_WW +: SMUL_WW] = prod[SMUL_WW-1:0];
    assign hi_vec[i*SMUL_WW +: SMUL_WW] = prod[2*SMUL_WW-1:SMUL_WW];
  end
endmodule

// File: rtl/smul_fold.sv
module smul_fold
  import smul_pkg::*;
#(
  parameter int unsigned NW = 64,
  localparam int unsigned AW = NW * SMUL_WW,
  localparam int unsigned SW = AW + SMUL_WW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic [AW-1:0] acc,
  input  logic [AW-1:0] lo_vec,
  input  logic [AW-1:0] hi_vec,
  output smul_word_t    out_word,
  output logic [AW-1:0] acc_next
);
  logic [SW-1:0] sum;

  // low halves at their own column, high halves one column up
  assign sum = {{(SMUL_WW+1){1'b0}}, acc} +
               {{(SMUL_WW+1){1'b0}}, lo_vec} +
               {1'b0, hi_vec, {SMUL_WW{1'b0}}};

  assign out_word = sum[SMUL_WW-1:0];
  assign acc_next = sum[SW-2:SMUL_WW];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> !sum[SW-1]); // R9
endmodule

// File: rtl/smul_ctrl.sv
module smul_ctrl
  import smul_pkg::*;
#(
  parameter int unsigned NW = 64,
  localparam int unsigned CW = $clog2(2*NW + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic full_mode,
  input  logic b_valid,
  input  logic r_valid,
  input  logic r_ready,
  output logic accept,
  output logic fire,
  output logic feeding,
  output logic b_ready,
  output logic last_step
);
  localparam logic [CW-1:0] N_STEPS  = CW'(NW);
  localparam logic [CW-1:0] N2_STEPS = CW'(2*NW);

  logic          run;
  logic          full_q;
  logic [CW-1:0] cnt;
  logic [CW-1:0] total;
  logic          out_free;

  assign total     = full_q ? N2_STEPS : N_STEPS;
  assign out_free  = !r_valid || r_ready;
  assign feeding   = (cnt < N_STEPS);
  assign accept    = start && !run && !r_valid;
  assign b_ready   = run && feeding && out_free;
  assign fire      = run && out_free && (!feeding || b_valid);
  assign last_step = (cnt == total - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      full_q <= 1'b0;
      cnt    <= '0;
    end else if (accept) begin
      run    <= 1'b1;
      full_q <= full_mode;
      cnt    <= '0;
    end else if (fire) begin
      cnt <= cnt + 1'b1;
      if (last_step) run <= 1'b0;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < total)); // R2
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (run && start && !fire) |=> (run && $stable(cnt))); // R8
  AST_FLUSH_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (run && fire && !feeding) |=> !b_ready); // R5
endmodule

// File: rtl/serial_bigmul.sv
module serial_bigmul
  import smul_pkg::*;
#(
  parameter int unsigned NW = 64,
  localparam int unsigned AW = NW * SMUL_WW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               full_mode,
  input  logic [AW-1:0]      a_in,
  input  logic               b_valid,
  output logic               b_ready,
  input  logic [SMUL_WW-1:0] b_word,
  output logic               r_valid,
  input  logic               r_ready,
  output logic [SMUL_WW-1:0] r_word,
  output logic               done
);
  logic          accept, fire, feeding, last_step;
  logic [AW-1:0] a_q, acc, acc_next, lo_vec, hi_vec;
  smul_word_t    m_word, fold_word;
  logic          r_last;

  assign m_word = feeding ? b_word : '0;

  smul_ctrl #(.NW(NW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .full_mode(full_mode),
    .b_valid(b_valid), .r_valid(r_valid), .r_ready(r_ready),
    .accept(accept), .fire(fire), .feeding(feeding), .b_ready(b_ready),
    .last_step(last_step)
  );

  smul_pp_row #(.NW(NW)) u_row (
    .a_vec(a_q), .m_word(m_word), .lo_vec(lo_vec), .hi_vec(hi_vec)
  );

  smul_fold #(.NW(NW)) u_fold (
    .clk(clk), .rst_n(rst_n), .step(fire), .acc(acc),
    .lo_vec(lo_vec), .hi_vec(hi_vec), .out_word(fold_word), .acc_next(acc_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q     <= '0;
      acc     <= '0;
      r_valid <= 1'b0;
      r_word  <= '0;
      r_last  <= 1'b0;
      done    <= 1'b0;
    end else begin
      if (accept) begin
        a_q  <= a_in;
        acc  <= '0;
        done <= 1'b0;
      end else if (fire) begin
        acc     <= acc_next;
        r_word  <= fold_word;
        r_valid <= 1'b1;
        r_last  <= last_step;
      end else if (r_valid && r_ready) begin
        r_valid <= 1'b0;
        r_last  <= 1'b0;
      end
      if (r_valid && r_ready && r_last) done <= 1'b1;
    end
  end

  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (r_valid && !r_ready) |=> (r_valid && $stable(r_word))); // R6
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!r_valid && !b_ready)); // R7
  AST_A_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (b_ready && !start) |=> $stable(a_q)); // R10
endmodule

// File: tb/serial_bigmul_bench.sv
`timescale 1ns/1ps
module serial_bigmul_bench;
  localparam int NW = 4;
  localparam int AW = NW * 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          full_mode = 1'b0;
  logic [AW-1:0] a_in = '0;
  logic          b_valid = 1'b0;
  logic          b_ready;
  logic [15:0]   b_word = '0;
  logic          r_valid;
  logic          r_ready = 1'b0;
  logic [15:0]   r_word;
  logic          done;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  serial_bigmul #(.NW(NW)) u_serial_bigmul (
    .clk(clk), .rst_n(rst_n), .start(start), .full_mode(full_mode),
    .a_in(a_in), .b_valid(b_valid), .b_ready(b_ready), .b_word(b_word),
    .r_valid(r_valid), .r_ready(r_ready), .r_word(r_word), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [2*AW-1:0] act, input logic [2*AW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [AW-1:0] a, input logic [AW-1:0] b,
                        input bit full, input bit stall, input bit poke,
                        input string tag);
    int total = full ? 2*NW : NW;
    logic [2*AW-1:0] exp = {{AW{1'b0}}, a} * {{AW{1'b0}}, b};
    logic [2*AW-1:0] got = '0;
    int nout = 0, nin = 0, cyc = 0;
    bit hold_bad = 0, flush_bad = 0, done_bad = 0;
    bit pv = 0;
    logic [15:0] pw = '0;
    @(negedge clk);
    start = 1'b1; a_in = a; full_mode = full;
    @(negedge clk);
    start = 1'b0;
    a_in = ~a;                                   // R10: late change
    full_mode = ~full;
    while (nout < total && cyc < 400) begin
      b_valid = (nin < NW) ? (($urandom % 4) != 0) : 1'b1;
      b_word  = (nin < NW) ? b[16*nin +: 16] : 16'($urandom);
      r_ready = stall ? (($urandom % 3) != 0) : 1'b1;
      start   = poke && (cyc == 2);             // R8: stray start
      if (poke) a_in = {$urandom, $urandom};
      #1;
      if (pv && !(r_valid && r_word == pw)) hold_bad = 1;
      if (nin >= NW && b_ready) flush_bad = 1;
      if (done) done_bad = 1;
      if (b_valid && b_ready) nin++;
      if (r_valid && r_ready) begin
        got[16*nout +: 16] = r_word;
        nout++;
      end
      pv = r_valid && !r_ready;
      pw = r_word;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0; b_valid = 1'b0; r_ready = 1'b0;
    #1;
    if (full) chk(got == exp, "R2", {tag, " full product"}, got, exp);
    else chk(got[AW-1:0] == exp[AW-1:0] && nout == NW, "R3", {tag, " truncated product"},
             got, {{AW{1'b0}}, exp[AW-1:0]});
    chk(nin == NW, "R4", {tag, " multiplier words taken"}, nin, NW);
    chk(!flush_bad, "R5", {tag, " b_ready low after N words"}, flush_bad, 0);
    if (stall) chk(!hold_bad, "R6", {tag, " word held under stall"}, hold_bad, 0);
    chk(!done_bad && done, "R7", {tag, " done timing"}, {done_bad, done}, 2'b01);
    if (poke) chk(got[AW-1:0] == exp[AW-1:0], "R8", {tag, " stray start ignored"},
                  got[AW-1:0], exp[AW-1:0]);
    chk(got[AW-1:0] == exp[AW-1:0], "R10", {tag, " multiplicand captured"},
        got[AW-1:0], exp[AW-1:0]);
    repeat (2) @(negedge clk);
    #1;
    chk(done && !r_valid, "R7", {tag, " done holds"}, {done, r_valid}, 2'b10);
  endtask

  initial begin
    #(8.0 * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [AW-1:0] ones = '1;
    b_valid = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(!r_valid && !b_ready && !done, "R1", "reset outputs",
        {r_valid, b_ready, done}, 3'b000);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(!r_valid && !b_ready && !done, "R1", "idle after reset",
        {r_valid, b_ready, done}, 3'b000);
    b_valid = 1'b0;
    for (int m = 0; m < 2; m++) begin
      run_op('0, '0, m[0], 0, 0, "zero");
      run_op(ones, ones, m[0], 0, 0, "R9 all-ones");
      run_op(ones, ones, m[0], 1, 1, "R9 all-ones stalled");
      run_op(64'd1, ones, m[0], 1, 0, "one");
      run_op(ones, 64'd1 << 63, m[0], 0, 0, "top bit");
      for (int i = 0; i < 30; i++)
        run_op({$urandom, $urandom}, {$urandom, $urandom}, m[0],
               i[0], i[1], "random");
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule